// File: doc/BRIEF.md
# Translation Fault Status Recorder

This block sits beside the instruction-side and data-side address translators. Each cycle it may accept one lookup. A lookup carries a virtual address, an access kind, a write flag, a user flag, the current privilege state and the trap level. The block compares the lookup with every entry of a fully associative translation table, all in parallel. Each entry is matched on its valid bit, its context and its virtual page number. One cycle after the lookup, the block reports one of three outcomes: a hit (with the index of the entry that matched), a protection fault, or a miss.

Faults and misses update a small set of 64-bit registers, one set per side. Each data-side fault builds a new status word from scratch and loads the faulting address. If the previous status was still valid, the new word also flags an overwrite. A miss leaves the status untouched and loads only the tag-access register, which combines the page address with the active context. Software reads these registers through a combinational select port and clears each side's status with a one-cycle strobe.

Top module: `fault_status_unit`

## Requirements
- R1: After reset, all five registers read as zero and `resp_code` is 0.
- R2: When `req_valid` is high, a lookup that matches an entry without a privilege violation makes `resp_code` equal 1 on the next cycle, with `resp_idx` set to the entry. No register changes. When `req_valid` is low, `resp_code` is 0 on the next cycle.
- R3: The lookup context is selected by `req_kind`. Kind 0 uses `ctx_primary`, kind 1 uses `ctx_secondary`, and kinds 2 and 3 use context 0.
- R4: A lookup whose matching entry has its privileged bit set, issued with `req_user` high, gives `resp_code` 2 on the next cycle.
- R5: A data-side protection fault replaces the whole data status word. The new word has bit 0 set to 1, bit 2 set to `req_write`, bit 3 set to `cpu_priv`, bits 5:4 set to `req_kind` and bit 7 set to 1. All other bits are zero, apart from bit 1 (see R6).
- R6: On a protection fault on either side, bit 1 of the new status word equals bit 0 of the old status word of that side.
- R7: A data-side protection fault loads the data fault address register with the lookup address, zero-extended to 64 bits.
- R8: An instruction-side protection fault sets the instruction status word to bit 0 = 1, bit 3 = `cpu_priv`, bits 5:4 = 2 if `trap_lvl` is nonzero and 0 otherwise, bit 7 = 1, plus bit 1 as in R6. It also loads the instruction tag-access register as described in R9.
- R9: A miss gives `resp_code` 3. It leaves the status and fault address registers unchanged. It loads that side's tag-access register with the address with bits 12:0 replaced by the 13-bit lookup context.
- R10: A clear strobe zeros that side's status word on the next cycle. If a fault on the same side is recorded in the same cycle as the clear, the fault value is stored instead.
- R11: `rd_data` shows a register chosen by `rd_sel` in the same cycle: 0 data status, 1 data fault address, 2 data tag-access, 3 instruction status, 4 instruction tag-access. Any other value reads as 0.
- R12: When several entries match, the lowest-numbered one is used for `resp_idx` and for the privilege check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup present this cycle |
| req_instr | input | 1 | 1 = instruction side, 0 = data side |
| req_va | input | VA_W | Virtual address of the lookup |
| req_kind | input | 2 | Access kind: 0 primary, 1 secondary, 2 nucleus, 3 untranslated |
| req_write | input | 1 | Store access |
| req_user | input | 1 | Access issued from user mode |
| cpu_priv | input | 1 | Processor privileged-state flag |
| trap_lvl | input | 3 | Current trap level |
| ctx_primary | input | 13 | Primary context value |
| ctx_secondary | input | 13 | Secondary context value |
| tlb_valid | input | N | Per-entry valid bits |
| tlb_priv | input | N | Per-entry privileged-only bits |
| tlb_ctx | input | N*13 | Per-entry contexts, entry i at bits 13*i+12:13*i |
| tlb_vpn | input | N*(VA_W-13) | Per-entry page numbers, entry i in slice i |
| clr_data | input | 1 | Clear the data status word |
| clr_instr | input | 1 | Clear the instruction status word |
| rd_sel | input | 3 | Register select for the read port |
| rd_data | output | 64 | Selected register |
| resp_code | output | 2 | Outcome pulse: 0 none, 1 hit, 2 protection fault, 3 miss |
| resp_idx | output | $clog2(N) | Index of the matched entry |

## Verification
Errors in this block reach the pins fast. A bad match vector or priority encoder shows up in `resp_code` and `resp_idx` one cycle after the lookup. A status word built from stale state shows up in `rd_data` in that same cycle. A valid bit that does not stick only becomes visible on the next fault, as a missing overwrite bit, so the sweep chains faults without clearing between them. Clears are mixed in at fixed intervals so that the overwrite bit is tested in both directions.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
   localparam int CTX_W  = 13;
   localparam int PAGE_W = 13;
   localparam int REG_W  = 64;

   typedef enum logic [1:0] {
      RSP_NONE = 2'd0,
      RSP_HIT  = 2'd1,
      RSP_PROT = 2'd2,
      RSP_MISS = 2'd3
   } resp_e;

   localparam int ST_VALID = 0;
   localparam int ST_OVWR  = 1;
   localparam int ST_WRITE = 2;
   localparam int ST_PRIV  = 3;
   localparam int ST_CT_LO = 4;
   localparam int ST_FTPRV = 7;

   localparam logic [1:0] CT_NUCLEUS = 2'd2;
endpackage

// File: rtl/fsu_match_array.sv
module fsu_match_array #(
   parameter int N     = 64,
   parameter int VPN_W = 51,
   parameter int CTX_W = 13
) (
   input  logic [VPN_W-1:0]   vpn,
   input  logic [CTX_W-1:0]   ctx,
   input  logic [N-1:0]       ent_valid,
   input  logic [N*CTX_W-1:0] ent_ctx,
   input  logic [N*VPN_W-1:0] ent_vpn,
   output logic [N-1:0]       hit_vec
);
   for (genvar g = 0; g < N; g++) begin : g_ent
      assign hit_vec[g] = ent_valid[g]
                        && (ent_ctx[g*CTX_W +: CTX_W] == ctx)
                        && (ent_vpn[g*VPN_W +: VPN_W] == vpn);
   end
endmodule

// File: rtl/fsu_lowest_pick.sv
module fsu_lowest_pick #(
   parameter int N     = 64,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req_vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_vec[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit
   import fsu_pkg::*;
#(
   parameter int N    = 64,
   parameter int VA_W = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_instr,
   input  logic [VA_W-1:0]          req_va,
   input  logic [1:0]               req_kind,
   input  logic                     req_write,
   input  logic                     req_user,
   input  logic                     cpu_priv,
   input  logic [2:0]               trap_lvl,
   input  logic [12:0]              ctx_primary,
   input  logic [12:0]              ctx_secondary,
   input  logic [N-1:0]             tlb_valid,
   input  logic [N-1:0]             tlb_priv,
   input  logic [N*13-1:0]          tlb_ctx,
   input  logic [N*(VA_W-13)-1:0]   tlb_vpn,
   input  logic                     clr_data,
   input  logic                     clr_instr,
   input  logic [2:0]               rd_sel,
   output logic [63:0]              rd_data,
   output logic [1:0]               resp_code,
   output logic [$clog2(N)-1:0]     resp_idx
);
   localparam int VPN_W = VA_W - PAGE_W;
   localparam int IDX_W = $clog2(N);

   if (VA_W <= PAGE_W || VA_W > REG_W) begin : g_bad_va
      $error("fault_status_unit: VA_W must be in 14..64");
   end
   if (N < 2) begin : g_bad_n
      $error("fault_status_unit: N must be at least 2");
   end

   logic [CTX_W-1:0] ctx_sel;
   logic [N-1:0]     hit_vec;
   logic             hit_any;
   logic [IDX_W-1:0] hit_idx;
   logic             prot;
   logic             d_fault, i_fault, d_miss, i_miss;
   logic [REG_W-1:0] d_sfsr, d_far, d_tag, i_sfsr, i_tag;
   logic [REG_W-1:0] d_new, i_new, tag_new;

   always_comb begin
      unique case (req_kind)
         2'd0:    ctx_sel = ctx_primary;
         2'd1:    ctx_sel = ctx_secondary;
         default: ctx_sel = '0;
      endcase
   end

   fsu_match_array #(.N(N), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_match (
      .vpn       (req_va[VA_W-1:PAGE_W]),
      .ctx       (ctx_sel),
      .ent_valid (tlb_valid),
      .ent_ctx   (tlb_ctx),
      .ent_vpn   (tlb_vpn),
      .hit_vec   (hit_vec)
   );

   fsu_lowest_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
      .req_vec (hit_vec),
      .any     (hit_any),
      .idx     (hit_idx)
   );

   assign prot    = hit_any && tlb_priv[hit_idx] && req_user;
   assign d_fault = req_valid && !req_instr && prot;
   assign i_fault = req_valid &&  req_instr && prot;
   assign d_miss  = req_valid && !req_instr && !hit_any;
   assign i_miss  = req_valid &&  req_instr && !hit_any;

   always_comb begin
      d_new = '0;
      d_new[ST_VALID] = 1'b1;
      d_new[ST_OVWR]  = d_sfsr[ST_VALID];
      d_new[ST_WRITE] = req_write;
      d_new[ST_PRIV]  = cpu_priv;
      d_new[ST_CT_LO +: 2] = req_kind;
      d_new[ST_FTPRV] = 1'b1;

      i_new = '0;
      i_new[ST_VALID] = 1'b1;
      i_new[ST_OVWR]  = i_sfsr[ST_VALID];
      i_new[ST_PRIV]  = cpu_priv;
      i_new[ST_CT_LO +: 2] = (trap_lvl != '0) ? CT_NUCLEUS : 2'd0;
      i_new[ST_FTPRV] = 1'b1;

      tag_new = REG_W'({req_va[VA_W-1:PAGE_W], ctx_sel});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_sfsr    <= '0;
         d_far     <= '0;
         d_tag     <= '0;
         i_sfsr    <= '0;
         i_tag     <= '0;
         resp_code <= RSP_NONE;
         resp_idx  <= '0;
      end else begin
         if (d_fault) begin
            d_sfsr <= d_new;
            d_far  <= REG_W'(req_va);
         end else if (clr_data) begin
            d_sfsr <= '0;
         end
         if (d_miss) d_tag <= tag_new;

         if (i_fault) begin
            i_sfsr <= i_new;
         end else if (clr_instr) begin
            i_sfsr <= '0;
         end
         if (i_fault || i_miss) i_tag <= tag_new;

         resp_idx <= hit_idx;
         if (!req_valid)   resp_code <= RSP_NONE;
         else if (!hit_any) resp_code <= RSP_MISS;
         else if (prot)    resp_code <= RSP_PROT;
         else              resp_code <= RSP_HIT;
      end
   end

   always_comb begin
      unique case (rd_sel)
         3'd0:    rd_data = d_sfsr;
         3'd1:    rd_data = d_far;
         3'd2:    rd_data = d_tag;
         3'd3:    rd_data = i_sfsr;
         3'd4:    rd_data = i_tag;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/fault_status_unit_chk.sv
module fault_status_unit_chk #(
   parameter int VA_W = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_instr,
   input logic [VA_W-1:0] req_va,
   input logic            clr_data,
   input logic [1:0]      resp_code,
   input logic [63:0]     d_sfsr,
   input logic [63:0]     d_far
);
   AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_code != 2'd0) |-> $past(req_valid)); // R2

   AST_FAULT_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_code == 2'd2 && !$past(req_instr)) |-> (d_sfsr[0] && d_sfsr[7])); // R4

   AST_OVERWRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_code == 2'd2 && !$past(req_instr)) |-> (d_sfsr[1] == $past(d_sfsr[0]))); // R6

   AST_FAR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_code == 2'd2 && !$past(req_instr)) |-> (d_far == 64'($past(req_va)))); // R7

   AST_MISS_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_code == 2'd3 && !$past(req_instr) && !$past(clr_data))
         |-> (d_sfsr == $past(d_sfsr) && d_far == $past(d_far))); // R9

   AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_data && !req_valid) |=> (d_sfsr == 64'd0)); // R10
endmodule

bind fault_status_unit fault_status_unit_chk #(.VA_W(VA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_instr (req_instr),
   .req_va    (req_va),
   .clr_data  (clr_data),
   .resp_code (resp_code),
   .d_sfsr    (d_sfsr),
   .d_far     (d_far)
);

// File: tb/tb_fault_status_unit.sv
`timescale 1ns/1ps
module tb_fault_status_unit;
   localparam int N     = 8;
   localparam int VA_W  = 32;
   localparam int VPN_W = VA_W - 13;
   localparam int IW    = $clog2(N);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, req_valid, req_instr, req_write, req_user, cpu_priv;
   logic [VA_W-1:0] req_va;
   logic [1:0] req_kind;
   logic [2:0] trap_lvl, rd_sel;
   logic [12:0] ctx_primary, ctx_secondary;
   logic [N-1:0] tlb_valid, tlb_priv;
   logic [N*13-1:0] tlb_ctx;
   logic [N*VPN_W-1:0] tlb_vpn;
   logic clr_data, clr_instr;
   logic [63:0] rd_data;
   logic [1:0] resp_code;
   logic [IW-1:0] resp_idx;

   logic [12:0]      bc [N];
   logic [VPN_W-1:0] bvpn [N];
   for (genvar g = 0; g < N; g++) begin : g_pack
      assign tlb_ctx[g*13 +: 13]       = bc[g];
      assign tlb_vpn[g*VPN_W +: VPN_W] = bvpn[g];
   end

   fault_status_unit #(.N(N), .VA_W(VA_W)) dut (.*);

   int total = 0, bad = 0;
   bit finished = 0;
   logic [63:0] m_reg [5];

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_regs();
      string tags [5] = '{"R5", "R7", "R9", "R8", "R8"};
      for (int s = 0; s < 5; s++) begin
         rd_sel = 3'(s);
         #1;
         check(tags[s], rd_data, m_reg[s]);
      end
   endtask

   // Drives one cycle of stimulus, predicts all registers, checks after the edge
   task automatic do_op(input bit vld, input bit side, input logic [VA_W-1:0] va,
                        input logic [1:0] kind, input bit w, input bit u, input bit p,
                        input logic [2:0] tl, input bit cd, input bit ci);
      logic [12:0] ctx;
      int idx;
      logic [1:0] exp_code;
      logic [63:0] ns, tag;
      @(negedge clk);
      req_valid = vld; req_instr = side; req_va = va; req_kind = kind;
      req_write = w; req_user = u; cpu_priv = p; trap_lvl = tl;
      clr_data = cd; clr_instr = ci;
      ctx = (kind == 2'd0) ? ctx_primary : (kind == 2'd1) ? ctx_secondary : 13'd0; // R3
      idx = -1;
      for (int i = N - 1; i >= 0; i--)
         if (tlb_valid[i] && bc[i] == ctx && bvpn[i] == va[VA_W-1:13]) idx = i;
      tag = 64'({va[VA_W-1:13], ctx});
      exp_code = !vld ? 2'd0 : (idx < 0) ? 2'd3 : (tlb_priv[idx] && u) ? 2'd2 : 2'd1;
      if (exp_code == 2'd2 && !side) begin
         ns = 64'h81 | (64'(m_reg[0][0]) << 1) | (64'(w) << 2) | (64'(p) << 3) | (64'(kind) << 4);
         m_reg[0] = ns; m_reg[1] = 64'(va);
      end else if (cd) m_reg[0] = '0;
      if (exp_code == 2'd2 && side) begin
         ns = 64'h81 | (64'(m_reg[3][0]) << 1) | (64'(p) << 3) | ((tl != 0) ? 64'h20 : 64'h0);
         m_reg[3] = ns; m_reg[4] = tag;
      end else if (ci) m_reg[3] = '0;
      if (exp_code == 2'd3) begin
         if (side) m_reg[4] = tag; else m_reg[2] = tag;
      end
      @(posedge clk);
      #1;
      req_valid = 0; clr_data = 0; clr_instr = 0;
      check("R4 code", 64'(resp_code), 64'(exp_code));
      if (exp_code == 2'd1 || exp_code == 2'd2) check("R12 idx", 64'(resp_idx), 64'(idx));
      check_regs();
   endtask

   initial begin
      #(20 * 20000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; req_valid = 0; req_instr = 0; req_va = '0; req_kind = 0;
      req_write = 0; req_user = 0; cpu_priv = 0; trap_lvl = 0; rd_sel = 0;
      ctx_primary = 13'h0123; ctx_secondary = 13'h1456;
      clr_data = 0; clr_instr = 0;
      tlb_valid = '0; tlb_priv = '0;
      for (int i = 0; i < N; i++) begin bc[i] = '0; bvpn[i] = '0; end
      for (int s = 0; s < 5; s++) m_reg[s] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 code", 64'(resp_code), 64'd0);
      check_regs();
      @(negedge clk); rst_n = 1;

      // Sweep: entry 0 privileged, its context retargeted per kind (R3 R4 R5 R6 R7 R8 R10)
      tlb_valid[0] = 1; tlb_priv[0] = 1; bvpn[0] = 19'h00055;
      begin
         int k = 0;
         for (int side = 0; side < 2; side++)
            for (int kind = 0; kind < 4; kind++)
               for (int bits = 0; bits < 16; bits++) begin
                  bc[0] = (kind == 0) ? ctx_primary : (kind == 1) ? ctx_secondary : 13'd0;
                  do_op(1, side[0], {19'h00055, 13'((k * 37) & 13'h1fff)}, 2'(kind),
                        bits[0], bits[1], bits[2], bits[3] ? 3'd3 : 3'd0,
                        (k % 5) == 4, (k % 7) == 6);
                  k++;
               end
      end

      // R9: misses on both sides and every kind leave status untouched
      for (int side = 0; side < 2; side++)
         for (int kind = 0; kind < 4; kind++)
            do_op(1, side[0], {19'h01234, 13'h0abc}, 2'(kind), 1, 1, 0, 3'd1, 0, 0);

      // R12: entries 2 and 5 both match; lowest wins, then the other after invalidation
      tlb_valid[2] = 1; tlb_valid[5] = 1; bvpn[2] = 19'h00077; bvpn[5] = 19'h00077;
      bc[2] = ctx_primary; bc[5] = ctx_primary; tlb_priv[5] = 1;
      do_op(1, 0, {19'h00077, 13'h0010}, 2'd0, 0, 1, 0, 3'd0, 0, 0);
      tlb_valid[2] = 0;
      do_op(1, 0, {19'h00077, 13'h0010}, 2'd0, 0, 1, 0, 3'd0, 0, 0);

      // R2: plain hit from user mode on a non-privileged entry, and no request
      tlb_valid[2] = 1;
      do_op(1, 1, {19'h00077, 13'h1fff}, 2'd0, 1, 1, 1, 3'd2, 0, 0);
      do_op(0, 0, {19'h00077, 13'h1fff}, 2'd0, 1, 1, 1, 3'd2, 0, 0);

      // R10: clears alone, then fault in the same cycle as clear
      do_op(0, 0, '0, 2'd0, 0, 0, 0, 3'd0, 1, 1);
      bc[0] = 13'd0;
      do_op(1, 0, {19'h00055, 13'h0001}, 2'd2, 1, 1, 1, 3'd0, 1, 0);
      do_op(1, 1, {19'h00055, 13'h0002}, 2'd3, 0, 1, 0, 3'd4, 0, 1);

      // R11: unused selects read zero
      for (int s = 5; s < 8; s++) begin
         rd_sel = 3'(s);
         #1;
         check("R11 unused select", rd_data, 64'd0);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule